// File: doc/BRIEF.md
# Power-Up Strap and Serial-EEPROM Configuration Loader

This block decides the device configuration at the end of reset. While reset is held, it samples a set of shared pins that double as LED drivers. These samples give the device's management address, a partition-select option and an EEPROM-enable option.

When EEPROM loading is not selected, the sampled straps become the configuration on the first clock after reset. When it is selected, the block reads a fixed number of 16-bit words from a Microwire-style serial EEPROM. Those words overwrite the configuration. The datapath-enable output stays low until the last word is stored.

During the load, one of the shared pins is driven as the EEPROM serial clock and the other shared pins are not driven. After configuration is complete, every shared pin drives the LED pattern supplied by the rest of the chip. A load happens only once per reset, whatever the loaded words contain.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high, the outputs are: `cfg_phy_addr`=0, `cfg_part_sel`=0, `cfg_port_en`=8'hFF, `cfg_ee_bit`=0, `cfg_done`=0, `dp_en`=0, `pin_oe`=0, `ee_cs`=0.
- R2: Straps are the value of `pin_i` at the last rising clock edge at which `rst` is high. Later changes on `pin_i` have no effect on the configuration.
- R3: If strap bit 6 is 0, then on the first clock edge with `rst` low the block sets the following, and no EEPROM transaction takes place:
  - `cfg_phy_addr` = strap[4:0]
  - `cfg_part_sel` = strap[5]
  - `cfg_port_en` = 8'hFF
  - `cfg_ee_bit` = 0
  - `cfg_done` = 1 and `dp_en` = 1
- R4: If strap bit 6 is 1, the block reads exactly `CFG_WORDS`=2 words at addresses WORD_BASE and WORD_BASE+1, in that order, with one frame per word. In each frame, `ee_cs` is high and `ee_di` sends 9 bits MSB first: start 1, opcode 10, then a 6-bit address. The EEPROM then returns 16 data bits, MSB first, on `ee_do`.
- R5: The serial clock on `pin_o[5]` has a period of 2*CLK_DIV clocks: low for the first half of each bit slot and high for the second. `ee_di` is stable while the clock is high. `ee_do` is sampled on the clock edge at which the serial clock rises. `ee_cs` is low for at least one slot between frames.
- R6: Word 0 gives `cfg_phy_addr`=bits[4:0], `cfg_part_sel`=bit 5 and `cfg_ee_bit`=bit 6. Word 1 gives `cfg_port_en`=bits[7:0]. All other bits are ignored.
- R7: During an EEPROM load, `cfg_done` and `dp_en` are low. `cfg_done` rises exactly one clock after the clock at which the last word updates the configuration. `dp_en` equals `cfg_done`.
- R8: During an EEPROM load, `pin_oe`=8'h20 (only pin 5 is driven, as the serial clock). Once `cfg_done` is high, `pin_oe`=8'hFF and `pin_o`=`led_i`.
- R9: After `cfg_done`, `ee_cs` stays low and `cfg_done` stays high until the next reset, even when the loaded `cfg_ee_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Values read back from the shared strap/LED pins |
| pin_o | output | 8 | Values driven onto the shared pins |
| pin_oe | output | 8 | Per-pin drive enable |
| led_i | input | 8 | LED pattern from the rest of the chip |
| ee_cs | output | 1 | EEPROM chip select |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_phy_addr | output | 5 | Management address |
| cfg_part_sel | output | 1 | Partition-select option |
| cfg_port_en | output | 8 | Per-port enable mask |
| cfg_ee_bit | output | 1 | Copy of the loaded EEPROM-enable bit |
| cfg_done | output | 1 | Configuration complete |
| dp_en | output | 1 | Main datapath enable |

## Verification
The bench inverts every strap pin right after reset release. A design that sampled the pins late, or kept sampling them, would report inverted addresses.

A behavioural EEPROM counts bit slots, checks the start bit, opcode and address of each frame, and times the serial clock period. A design with an off-by-one slot count would return shifted words, and a design sending the wrong opcode or address would be flagged.

The bench measures the cycle distance between the last configuration change and the rise of `cfg_done`. It also loads a word with the enable bit set and waits afterwards, so that a premature done or a second load becomes visible. Resetting in the middle of a load confirms that the chip select drops at once and that the new straps take over.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    // Shared pin and field layout
    localparam int PIN_W      = 8;
    localparam int PHY_W      = 5;
    localparam int PORT_W     = 8;
    localparam int WORD_W     = 16;
    localparam int PART_PIN   = 5;
    localparam int EE_PIN     = 6;
    localparam int SK_PIN     = 5;
    localparam int CFG_WORDS  = 2;
    localparam int EE_ADDR_W  = 6;
    localparam int W0_PART_B  = 5;
    localparam int W0_EE_B    = 6;
    localparam logic [2:0] EE_RD_CMD = 3'b110;

    typedef struct packed {
        logic              ee_bit;
        logic [PORT_W-1:0] port_en;
        logic              part_sel;
        logic [PHY_W-1:0]  phy_addr;
    } cfg_t;

    typedef enum logic [1:0] {PM_HIZ, PM_EE, PM_LED} pin_mode_t;
    typedef enum logic [1:0] {ST_BOOT, ST_LOAD, ST_FIN, ST_DONE} ld_state_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c         = '0;
        c.port_en = '1;
        return c;
    endfunction

    function automatic cfg_t cfg_from_strap(input logic [PIN_W-1:0] p);
        cfg_t c;
        c          = cfg_default();
        c.phy_addr = p[PHY_W-1:0];
        c.part_sel = p[PART_PIN];
        return c;
    endfunction

    function automatic cfg_t cfg_merge(input cfg_t c, input int idx,
                                       input logic [WORD_W-1:0] w);
        cfg_t r;
        r = c;
        case (idx)
            0: begin
                r.phy_addr = w[PHY_W-1:0];
                r.part_sel = w[W0_PART_B];
                r.ee_bit   = w[W0_EE_B];
            end
            1: r.port_en = w[PORT_W-1:0];
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgld_strap_latch.sv
module cfgld_strap_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] strap_o
);
    logic [W-1:0] strap_q;

    // Keep sampling throughout reset; freeze at release
    always_ff @(posedge clk) begin
        if (rst) strap_q <= pin_i;
    end

    assign strap_o = strap_q;

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(strap_q));

endmodule

// File: rtl/cfgld_ee_reader.sv
module cfgld_ee_reader
    import cfgld_pkg::*;
#(
    parameter int DIV    = 2,
    parameter int NWORDS = CFG_WORDS,
    parameter int BASE   = 0,
    localparam int WI_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ee_do_i,
    output logic              busy_o,
    output logic              cs_o,
    output logic              sk_o,
    output logic              di_o,
    output logic              wr_stb_o,
    output logic [WI_W-1:0]   wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              wr_last_o
);
    localparam int SLOT_CYC   = 2 * DIV;
    localparam int PH_W       = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam int CMD_BITS   = 3 + EE_ADDR_W;
    localparam int FIRST_DATA = 1 + CMD_BITS;
    localparam int FRAME      = FIRST_DATA + WORD_W;
    localparam int SL_W       = $clog2(FRAME);

    logic                busy_q;
    logic [PH_W-1:0]     ph_q;
    logic [SL_W-1:0]     slot_q;
    logic [WI_W-1:0]     widx_q;
    logic [WORD_W-1:0]   sh_q;
    logic                ph_end, frame_end, sample, last_word;
    logic [CMD_BITS-1:0] cmd_vec, cmd_sh;

    assign ph_end    = (ph_q == PH_W'(SLOT_CYC - 1));
    assign frame_end = (slot_q == SL_W'(FRAME - 1));
    assign last_word = (widx_q == WI_W'(NWORDS - 1));
    assign sample    = busy_q && (slot_q >= SL_W'(FIRST_DATA)) && (ph_q == PH_W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            slot_q <= '0;
            widx_q <= '0;
            sh_q   <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                ph_q   <= '0;
                slot_q <= '0;
                widx_q <= '0;
            end
        end else begin
            if (sample) sh_q <= {sh_q[WORD_W-2:0], ee_do_i};
            if (ph_end) begin
                ph_q <= '0;
                if (frame_end) begin
                    slot_q <= '0;
                    if (last_word) busy_q <= 1'b0;
                    else           widx_q <= widx_q + 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    // Slot 0 of every frame is the chip-select gap
    assign cs_o    = busy_q && (slot_q != '0);
    assign sk_o    = cs_o && (ph_q >= PH_W'(DIV));
    assign cmd_vec = {EE_RD_CMD, EE_ADDR_W'(BASE + int'(widx_q))};
    assign cmd_sh  = cmd_vec << (slot_q - SL_W'(1));

    always_comb begin
        di_o = 1'b0;
        if (cs_o && (slot_q <= SL_W'(CMD_BITS))) di_o = cmd_sh[CMD_BITS-1];
    end

    assign busy_o    = busy_q;
    assign wr_stb_o  = busy_q && ph_end && frame_end;
    assign wr_idx_o  = widx_q;
    assign wr_data_o = sh_q;
    assign wr_last_o = last_word;

    // R5
    di_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sk_o && $past(sk_o)) |-> $stable(di_o));

    // R5
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !cs_o);

endmodule

// File: rtl/cfgld_pin_mux.sv
module cfgld_pin_mux
    import cfgld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pin_mode_t        mode_i,
    input  logic             sk_i,
    input  logic [PIN_W-1:0] led_i,
    output logic [PIN_W-1:0] pin_o,
    output logic [PIN_W-1:0] pin_oe
);
    always_comb begin
        pin_o  = '0;
        pin_oe = '0;
        case (mode_i)
            PM_EE: begin
                pin_oe[SK_PIN] = 1'b1;
                pin_o[SK_PIN]  = sk_i;
            end
            PM_LED: begin
                pin_oe = '1;
                pin_o  = led_i;
            end
            default: ;
        endcase
    end

    // R8
    strap_pins_free_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i != PM_LED) |-> $onehot0(pin_oe));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CLK_DIV   = 2,
    parameter int WORD_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [PIN_W-1:0]  pin_o,
    output logic [PIN_W-1:0]  pin_oe,
    input  logic [PIN_W-1:0]  led_i,
    output logic              ee_cs,
    output logic              ee_di,
    input  logic              ee_do,
    output logic [PHY_W-1:0]  cfg_phy_addr,
    output logic              cfg_part_sel,
    output logic [PORT_W-1:0] cfg_port_en,
    output logic              cfg_ee_bit,
    output logic              cfg_done,
    output logic              dp_en
);
    localparam int WI_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;

    logic [PIN_W-1:0]  strap;
    ld_state_t         st_q;
    cfg_t              cfg_q;
    pin_mode_t         pmode;
    logic              rd_start, rd_busy, rd_sk, rd_stb, rd_last;
    logic [WI_W-1:0]   rd_idx;
    logic [WORD_W-1:0] rd_data;

    cfgld_strap_latch #(.W(PIN_W)) u_strap (
        .clk(clk), .rst(rst), .pin_i(pin_i), .strap_o(strap)
    );

    assign rd_start = (st_q == ST_BOOT) && strap[EE_PIN];

    cfgld_ee_reader #(.DIV(CLK_DIV), .NWORDS(CFG_WORDS), .BASE(WORD_BASE)) u_rd (
        .clk(clk), .rst(rst), .start_i(rd_start), .ee_do_i(ee_do),
        .busy_o(rd_busy), .cs_o(ee_cs), .sk_o(rd_sk), .di_o(ee_di),
        .wr_stb_o(rd_stb), .wr_idx_o(rd_idx), .wr_data_o(rd_data),
        .wr_last_o(rd_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_BOOT;
            cfg_q <= cfg_default();
        end else begin
            case (st_q)
                ST_BOOT: begin
                    if (strap[EE_PIN]) begin
                        st_q <= ST_LOAD;
                    end else begin
                        cfg_q <= cfg_from_strap(strap);
                        st_q  <= ST_DONE;
                    end
                end
                ST_LOAD: begin
                    if (rd_stb) begin
                        cfg_q <= cfg_merge(cfg_q, int'(rd_idx), rd_data);
                        if (rd_last) st_q <= ST_FIN;
                    end
                end
                ST_FIN:  st_q <= ST_DONE;
                default: st_q <= ST_DONE;
            endcase
        end
    end

    always_comb begin
        case (st_q)
            ST_LOAD, ST_FIN: pmode = PM_EE;
            ST_DONE:         pmode = PM_LED;
            default:         pmode = PM_HIZ;
        endcase
    end

    cfgld_pin_mux u_pins (
        .clk(clk), .rst(rst), .mode_i(pmode), .sk_i(rd_sk),
        .led_i(led_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    assign cfg_phy_addr = cfg_q.phy_addr;
    assign cfg_part_sel = cfg_q.part_sel;
    assign cfg_port_en  = cfg_q.port_en;
    assign cfg_ee_bit   = cfg_q.ee_bit;
    assign cfg_done     = (st_q == ST_DONE);
    assign dp_en        = cfg_done;

    // R7
    done_after_store_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_last) |=> (!cfg_done ##1 cfg_done));

    // R7
    dp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rd_busy |-> !dp_en);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    // R9
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !ee_cs);

endmodule

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int NVEC       = 5;
    // {pins, word0, word1, exp_addr, exp_port, exp_part, exp_ee, 6'b0}
    localparam logic [63:0] VEC [NVEC] = '{
        64'h2B_0000_0000_0B_FF_80,
        64'h9F_0000_0000_1F_FF_00,
        64'h4A_FF35_AB3C_15_3C_80,
        64'h7F_0040_5A81_00_81_40,
        64'hC0_801F_FF00_1F_00_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_i = 8'h00;
    logic [7:0] pin_o, pin_oe;
    logic [7:0] led_i = 8'h00;
    logic       ee_cs, ee_di;
    logic       ee_do = 1'b0;
    logic [4:0] cfg_phy_addr;
    logic       cfg_part_sel;
    logic [7:0] cfg_port_en;
    logic       cfg_ee_bit, cfg_done, dp_en;

    int tests = 0, fails = 0, cyc = 0;
    int frames = 0, fil = 0, bitcnt = 0, gap = 0;
    int bad_cmd = 0, per_err = 0, oe_err = 0, dp_err = 0;
    int last_chg = 0, done_cyc = 0;
    logic [8:0]  cmd_sr = '0;
    logic [15:0] mem0 = '0, mem1 = '0, wsel;
    logic        sk_prev = 1'b0, cs_prev = 1'b0, done_prev = 1'b0;
    logic [14:0] cat_prev = '0;
    bit          wd = 1'b0;

    wire sk_pin = pin_oe[5] & pin_o[5];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_loader #(.CLK_DIV(DIV), .WORD_BASE(0)) u_cfg_loader (
        .clk(clk), .rst(rst), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .led_i(led_i), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do(ee_do),
        .cfg_phy_addr(cfg_phy_addr), .cfg_part_sel(cfg_part_sel),
        .cfg_port_en(cfg_port_en), .cfg_ee_bit(cfg_ee_bit),
        .cfg_done(cfg_done), .dp_en(dp_en)
    );

    function automatic logic [15:0] word_at(input logic [5:0] a);
        if (a == 6'd0) return mem0;
        if (a == 6'd1) return mem1;
        return 16'hDEAD;
    endfunction

    // Behavioural serial EEPROM plus output monitor
    always @(negedge clk) begin
        if (rst) fil = 0;
        if (ee_cs && !cs_prev) begin
            frames++; fil++; bitcnt = 0; gap = 0;
        end
        if (!ee_cs) bitcnt = 0;
        if (ee_cs) begin
            gap++;
            if (sk_pin && !sk_prev) begin
                if (bitcnt > 0 && gap != 2*DIV) per_err++;
                gap = 0;
                if (bitcnt < 9) cmd_sr = {cmd_sr[7:0], ee_di};
                bitcnt++;
                if (bitcnt == 9 && (cmd_sr[8:6] != 3'b110 || cmd_sr[5:0] != 6'(fil-1)))
                    bad_cmd++;
            end else if (!sk_pin && sk_prev && bitcnt >= 9 && bitcnt < 25) begin
                wsel  = word_at(cmd_sr[5:0]);
                ee_do = wsel[24-bitcnt];
            end
            if (pin_oe != 8'h20) oe_err++;
            if (cfg_done || dp_en) dp_err++;
        end
        if ({cfg_phy_addr, cfg_part_sel, cfg_port_en, cfg_ee_bit} != cat_prev) last_chg = cyc;
        cat_prev = {cfg_phy_addr, cfg_part_sel, cfg_port_en, cfg_ee_bit};
        if (cfg_done && !done_prev) done_cyc = cyc;
        done_prev = cfg_done;
        sk_prev = sk_pin;
        cs_prev = ee_cs;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R1: reset state check, then release with pins inverted (R2)
    task automatic do_reset(input logic [7:0] strap, output int rel);
        rst = 1'b1;
        pin_i = strap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({cfg_phy_addr, cfg_part_sel, cfg_port_en, cfg_ee_bit} == {5'd0, 1'b0, 8'hFF, 1'b0},
            "R1 cfg", {cfg_phy_addr, cfg_part_sel, cfg_port_en, cfg_ee_bit}, {5'd0, 1'b0, 8'hFF, 1'b0});
        chk({cfg_done, dp_en, ee_cs} == 3'b000, "R1 done/dp/cs", {cfg_done, dp_en, ee_cs}, 0);
        chk(pin_oe == 8'h00, "R1 pin_oe", pin_oe, 0);
        rst = 1'b0;
        pin_i = ~strap;
        rel = cyc;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !cfg_done; i++) @(negedge clk);
        chk(cfg_done, "R7 done reached", cfg_done, 1);
    endtask

    task automatic run_all();
        int rel, f0, bc0, pe0, oe0, dp0;
        logic [63:0] v;
        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            mem0 = v[55:40];
            mem1 = v[39:24];
            f0 = frames; bc0 = bad_cmd; pe0 = per_err; oe0 = oe_err; dp0 = dp_err;
            do_reset(v[63:56], rel);
            wait_done();
            @(negedge clk);
            chk({cfg_phy_addr, cfg_port_en, cfg_part_sel, cfg_ee_bit} ==
                {v[20:16], v[15:8], v[7], v[6]},
                v[62] ? "R6 loaded fields" : "R3 R2 strap fields",
                {cfg_phy_addr, cfg_port_en, cfg_part_sel, cfg_ee_bit},
                {v[20:16], v[15:8], v[7], v[6]});
            chk(dp_en == cfg_done, "R7 dp_en follows done", dp_en, cfg_done);
            if (v[62]) begin
                chk(frames - f0 == 2, "R4 frame count", frames - f0, 2);
                chk(bad_cmd == bc0, "R4 command/address", bad_cmd - bc0, 0);
                chk(per_err == pe0, "R5 serial clock period", per_err - pe0, 0);
                chk(oe_err == oe0, "R8 pins during load", oe_err - oe0, 0);
                chk(dp_err == dp0, "R7 done/dp low in load", dp_err - dp0, 0);
                chk(done_cyc - last_chg == 1, "R7 done one cycle after store",
                    done_cyc - last_chg, 1);
            end else begin
                chk(frames == f0, "R3 no EEPROM access", frames - f0, 0);
                chk(done_cyc - rel == 1, "R3 done on first edge", done_cyc - rel, 1);
            end
            repeat (300) @(negedge clk);
            chk(frames - f0 == (v[62] ? 2 : 0), "R9 no reload", frames - f0, v[62] ? 2 : 0);
            chk(cfg_done && !ee_cs, "R9 done held, cs low", {cfg_done, ee_cs}, 2'b10);
            led_i = 8'h5A ^ 8'(k);
            @(negedge clk);
            chk(pin_oe == 8'hFF && pin_o == led_i, "R8 LED drive", {pin_oe, pin_o}, {8'hFF, led_i});
        end

        // Directed: reset in the middle of a load, new straps select no EEPROM
        mem0 = 16'h0011; mem1 = 16'h0022;
        do_reset(8'h4A, rel);
        repeat (60) @(negedge clk);
        chk(ee_cs && !cfg_done, "R7 load in progress", {ee_cs, cfg_done}, 2'b10);
        f0 = frames;
        do_reset(8'h05, rel);
        wait_done();
        chk({cfg_phy_addr, cfg_part_sel, cfg_port_en} == {5'h05, 1'b0, 8'hFF},
            "R3 after aborted load", {cfg_phy_addr, cfg_part_sel, cfg_port_en}, {5'h05, 1'b0, 8'hFF});
        repeat (200) @(negedge clk);
        chk(frames == f0, "R9 aborted load not resumed", frames - f0, 0);

        // Directed: straps change during reset; the last sampled value wins
        rst = 1'b1;
        pin_i = 8'h11;
        repeat (3) @(posedge clk);
        do_reset(8'h23, rel);
        wait_done();
        chk({cfg_phy_addr, cfg_part_sel} == {5'h03, 1'b1}, "R2 last reset sample",
            {cfg_phy_addr, cfg_part_sel}, {5'h03, 1'b1});
    endtask

    initial begin
        fork
            run_all();
            begin
                #(CLK_PERIOD * 150000);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule